// File: doc/BRIEF.md
# Read-Only Performance Counter Bank

This block holds a set of 64-bit event counters that a 32-bit core reads through its control-register read port. Three counters have fixed jobs. Slot 0 counts core clock cycles while the core is running. Slot 1 counts ticks of an external real-time strobe. Slot 2 counts instructions that retire without a synchronous exception. Above these sit a configurable number of generic counters, and each one follows its own event strobe.

Software reads the lower 32 bits of a counter from one address window and the upper 32 bits from a second window. No counter can be written. Any access with write intent is reported as illegal. An access to an unimplemented slot is either reported as illegal or answered with a fixed constant, and a parameter picks which. The response is registered and appears one cycle after the request. Addresses outside both windows are left to the rest of the control-register file: the block answers them with zero and no flag.

Top module: `perf_counter_bank`

## Requirements
- R1: The lower half of counter i is read at address 0xC00+i and the upper half at 0xC80+i, for i from 0 to 31. The response appears on the outputs in the cycle after `csr_req_i` is high. In a cycle after no request, both outputs are zero.
- R2: Every counter is 64 bits wide. A lower-half read returns bits 31:0 and an upper-half read returns bits 63:32. A carry into bit 32 lands in the same cycle as the increment that causes it.
- R3: Counter 0 rises by one on each clock edge where `core_active_i` is 1, and holds while it is 0.
- R4: Counter 1 rises by one on each clock edge where `rtc_tick_i` is 1. A read of counter 1 issued in the same cycle as a tick returns the value from before that tick.
- R5: Counter 2 rises by one when `retire_i` is 1 and `retire_exc_i` is 0. It does not change when `retire_exc_i` is 1.
- R6: Generic counter k sits at slot 3+k and rises by one in each cycle where `event_i[k]` is 1. Any number of generic counters may rise in the same cycle.
- R7: `csr_op_i` is encoded as 00 plain read, 01 swap, 10 set and 11 clear. A plain read is legal. A set or clear with `csr_src_zero_i`=1 is also legal. A legal read returns the counter half with `csr_illegal_o`=0.
- R8: A swap, or a set or clear with `csr_src_zero_i`=0, to either window sets `csr_illegal_o`=1 and returns zero data. The counter keeps counting only its own events.
- R9: Slots at or above 3+NUM_HPM are unimplemented. With UNIMPL_TRAP=1 a read of such a slot gives `csr_illegal_o`=1 and zero data. With UNIMPL_TRAP=0 it returns UNIMPL_VALUE with no flag.
- R10: A request to an address outside both windows returns zero data with `csr_illegal_o`=0.
- R11: After reset every counter is zero and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_active_i | input | 1 | High while the core is clocked and powered, enables the cycle counter |
| rtc_tick_i | input | 1 | Real-time tick strobe, one cycle per tick |
| retire_i | input | 1 | An instruction retires this cycle |
| retire_exc_i | input | 1 | The retiring instruction raised a synchronous exception |
| event_i | input | NUM_HPM | One event strobe per generic counter |
| csr_req_i | input | 1 | Control-register access request |
| csr_addr_i | input | 12 | Control-register address |
| csr_op_i | input | 2 | Access operation (00 read, 01 swap, 10 set, 11 clear) |
| csr_src_zero_i | input | 1 | The set/clear operand is register zero or immediate zero |
| csr_rdata_o | output | 32 | Read data, registered |
| csr_illegal_o | output | 1 | Illegal access flag, registered |

## Verification
Read data and the illegal flag are due exactly one clock edge after the request cycle. A counter reflects its strobe at the edge where the strobe is sampled. The bench therefore drives all inputs on the falling edge and snapshots its expected value from a reference model at that same falling edge, which gives the pre-increment value for a read that coincides with an event. It then compares the outputs at the next falling edge. The reference model advances on every rising edge from the same strobes, so the value expected for each read accounts for every increment that has landed before the read.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

    localparam int unsigned CTR_W   = 64;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned N_FIXED = 3;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned ADDR_W  = 12;

    // address bits 11:5 select a window of 32 slots
    localparam logic [ADDR_W-IDX_W-1:0] LO_WINDOW = 7'h60;
    localparam logic [ADDR_W-IDX_W-1:0] HI_WINDOW = 7'h64;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic             hit;
        logic             high;
        logic [IDX_W-1:0] idx;
        logic             wr_intent;
        logic             impl;
    } csr_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] rdata;
        logic            illegal;
    } csr_rsp_t;

endpackage

// File: rtl/perf_ctr_cell.sv
module perf_ctr_cell #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [WIDTH-1:0] count_o
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cell_state_t;

    cell_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (inc_i) begin
            state_d.count = state_q.count + WIDTH'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;

    // R6
    count_moves_only_on_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != $past(count_o)) |-> $past(inc_i));

endmodule

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
    import perf_ctr_pkg::*;
#(
    parameter int unsigned NUM_HPM = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        op_i,
    input  logic              src_zero_i,
    output csr_dec_t          dec_o
);

    localparam int unsigned NUM_CTR = N_FIXED + NUM_HPM;

    csr_op_e                  op;
    logic [ADDR_W-IDX_W-1:0]  window;

    always_comb begin
        op     = csr_op_e'(op_i);
        window = addr_i[ADDR_W-1:IDX_W];

        dec_o.hit       = (window == LO_WINDOW) || (window == HI_WINDOW);
        dec_o.high      = (window == HI_WINDOW);
        dec_o.idx       = addr_i[IDX_W-1:0];
        dec_o.wr_intent = (op == OP_SWAP)
                        || (((op == OP_SET) || (op == OP_CLR)) && !src_zero_i);
        dec_o.impl      = (32'(addr_i[IDX_W-1:0]) < NUM_CTR);
    end

endmodule

// File: rtl/perf_read_port.sv
module perf_read_port
    import perf_ctr_pkg::*;
#(
    parameter int unsigned NUM_CTR      = 7,
    parameter bit          UNIMPL_TRAP  = 1'b1,
    parameter logic [31:0] UNIMPL_VALUE = 32'h0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          req_i,
    input  csr_dec_t                      dec_i,
    input  logic [NUM_CTR-1:0][CTR_W-1:0] counters_i,
    output logic [XLEN-1:0]               rdata_o,
    output logic                          illegal_o
);

    csr_rsp_t         rsp_d, rsp_q;
    logic [CTR_W-1:0] sel;
    logic [XLEN-1:0]  half;

    always_comb begin
        sel = '0;
        for (int i = 0; i < int'(NUM_CTR); i++) begin
            if (dec_i.idx == IDX_W'(i)) begin
                sel = counters_i[i];
            end
        end
        half = dec_i.high ? sel[CTR_W-1:XLEN] : sel[XLEN-1:0];

        rsp_d = '0;
        if (req_i && dec_i.hit) begin
            if (dec_i.wr_intent) begin
                rsp_d.illegal = 1'b1;
            end else if (!dec_i.impl) begin
                if (UNIMPL_TRAP) begin
                    rsp_d.illegal = 1'b1;
                end else begin
                    rsp_d.rdata = UNIMPL_VALUE;
                end
            end else begin
                rsp_d.rdata = half;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rdata_o   = rsp_q.rdata;
    assign illegal_o = rsp_q.illegal;

    // R8
    illegal_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> $past(req_i));

    // R1
    idle_response_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> (rdata_o == '0) && !illegal_o);

    // R9
    illegal_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (rdata_o == '0));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import perf_ctr_pkg::*;
#(
    parameter int unsigned NUM_HPM      = 4,
    parameter bit          UNIMPL_TRAP  = 1'b1,
    parameter logic [31:0] UNIMPL_VALUE = 32'h0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               core_active_i,
    input  logic               rtc_tick_i,
    input  logic               retire_i,
    input  logic               retire_exc_i,
    input  logic [NUM_HPM-1:0] event_i,
    input  logic               csr_req_i,
    input  logic [11:0]        csr_addr_i,
    input  logic [1:0]         csr_op_i,
    input  logic               csr_src_zero_i,
    output logic [31:0]        csr_rdata_o,
    output logic               csr_illegal_o
);

    localparam int unsigned NUM_CTR = N_FIXED + NUM_HPM;

    logic [NUM_CTR-1:0]            inc;
    logic [NUM_CTR-1:0][CTR_W-1:0] counts;
    csr_dec_t                      dec;

    always_comb begin
        inc[0] = core_active_i;
        inc[1] = rtc_tick_i;
        inc[2] = retire_i && !retire_exc_i;
        inc[NUM_CTR-1:N_FIXED] = event_i;
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        perf_ctr_cell #(.WIDTH(CTR_W)) u_cell (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .inc_i   (inc[g]),
            .count_o (counts[g])
        );
    end

    perf_csr_decode #(.NUM_HPM(NUM_HPM)) u_decode (
        .addr_i     (csr_addr_i),
        .op_i       (csr_op_i),
        .src_zero_i (csr_src_zero_i),
        .dec_o      (dec)
    );

    perf_read_port #(
        .NUM_CTR      (NUM_CTR),
        .UNIMPL_TRAP  (UNIMPL_TRAP),
        .UNIMPL_VALUE (UNIMPL_VALUE)
    ) u_read (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (csr_req_i),
        .dec_i      (dec),
        .counters_i (counts),
        .rdata_o    (csr_rdata_o),
        .illegal_o  (csr_illegal_o)
    );

    // R3
    cycle_hold_when_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !core_active_i |=> $stable(counts[0]));

    // R4
    time_hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rtc_tick_i |=> $stable(counts[1]));

    // R5
    faulting_retire_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_i && retire_exc_i) |=> $stable(counts[2]));

endmodule

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;

    localparam int unsigned NHPM  = 4;
    localparam int unsigned NCTR  = 3 + NHPM;
    localparam logic [31:0] CONST = 32'hC0FF_EE00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic active, tick, retire, exc;
    logic [NHPM-1:0] ev;
    logic req = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0] op = '0;
    logic zero = 1'b1;
    logic [31:0] rdata_a, rdata_b;
    logic ill_a, ill_b;

    logic rand_en = 1'b0;
    logic dir_active = 1'b0, dir_tick = 1'b0, dir_retire = 1'b0, dir_exc = 1'b0;
    logic [NHPM-1:0] dir_ev = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] mdl [NCTR];

    always #10 clk = ~clk;

    perf_counter_bank #(.NUM_HPM(NHPM), .UNIMPL_TRAP(1'b1)) u_perf_counter_bank (
        .clk_i(clk), .rst_ni(rst_n), .core_active_i(active), .rtc_tick_i(tick),
        .retire_i(retire), .retire_exc_i(exc), .event_i(ev), .csr_req_i(req),
        .csr_addr_i(addr), .csr_op_i(op), .csr_src_zero_i(zero),
        .csr_rdata_o(rdata_a), .csr_illegal_o(ill_a));

    perf_counter_bank #(.NUM_HPM(NHPM), .UNIMPL_TRAP(1'b0), .UNIMPL_VALUE(CONST)) u_const (
        .clk_i(clk), .rst_ni(rst_n), .core_active_i(active), .rtc_tick_i(tick),
        .retire_i(retire), .retire_exc_i(exc), .event_i(ev), .csr_req_i(req),
        .csr_addr_i(addr), .csr_op_i(op), .csr_src_zero_i(zero),
        .csr_rdata_o(rdata_b), .csr_illegal_o(ill_b));

    always @(negedge clk) begin
        if (rand_en) begin
            active <= 1'($urandom % 4 != 0);
            tick   <= 1'($urandom % 3 == 0);
            retire <= 1'($urandom % 2);
            exc    <= 1'($urandom % 4 == 0);
            ev     <= NHPM'($urandom);
        end else begin
            active <= dir_active;
            tick   <= dir_tick;
            retire <= dir_retire;
            exc    <= dir_exc;
            ev     <= dir_ev;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NCTR); i++) mdl[i] <= '0;
        end else begin
            mdl[0] <= mdl[0] + 64'(active);
            mdl[1] <= mdl[1] + 64'(tick);
            mdl[2] <= mdl[2] + 64'(retire && !exc);
            for (int k = 0; k < int'(NHPM); k++) mdl[3+k] <= mdl[3+k] + 64'(ev[k]);
        end
    end

    function automatic void expect_rsp(input logic [11:0] a, input logic [1:0] o,
                                       input logic z, input bit trap,
                                       output logic [31:0] d, output logic il);
        bit hit, hi, wr, impl;
        int idx;
        hit  = (a[11:5] == 7'h60) || (a[11:5] == 7'h64);
        hi   = a[7];
        idx  = int'(a[4:0]);
        wr   = (o == 2'b01) || ((o[1] == 1'b1) && !z);
        impl = idx < int'(NCTR);
        d = '0;
        il = 1'b0;
        if (!hit) begin
        end else if (wr) begin
            il = 1'b1;
        end else if (!impl) begin
            if (trap) il = 1'b1;
            else d = CONST;
        end else begin
            d = hi ? mdl[idx][63:32] : mdl[idx][31:0];
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act_d, input logic act_i,
                         input logic [31:0] exp_d, input logic exp_i);
        checks++;
        if (act_d !== exp_d || act_i !== exp_i) begin
            errors++;
            $display("FAIL %s: data=%h illegal=%b expected data=%h illegal=%b",
                     tag, act_d, act_i, exp_d, exp_i);
        end
    endtask

    task automatic do_req(input logic [11:0] a, input logic [1:0] o, input logic z,
                          input string tag);
        logic [31:0] ea, eb;
        logic ia, ib;
        @(negedge clk);
        req = 1'b1; addr = a; op = o; zero = z;
        expect_rsp(a, o, z, 1'b1, ea, ia);
        expect_rsp(a, o, z, 1'b0, eb, ib);
        @(negedge clk);
        check(tag, rdata_a, ill_a, ea, ia);
        check({tag, " const"}, rdata_b, ill_b, eb, ib);
        req = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the outputs and in the counters
        check("R11 idle outputs", rdata_a, ill_a, 32'h0, 1'b0);
        do_req(12'hC00, 2'b00, 1'b1, "R11 cycle after reset");
        do_req(12'hC83, 2'b00, 1'b1, "R11 generic high after reset");

        // R3: cycle counter runs only while the core is active
        dir_active = 1'b1;
        repeat (10) @(negedge clk);
        dir_active = 1'b0;
        do_req(12'hC00, 2'b00, 1'b1, "R3 cycle after run");
        repeat (6) @(negedge clk);
        do_req(12'hC00, 2'b10, 1'b1, "R3 cycle holds while gated");

        // R4: tick coinciding with a read returns the old value
        dir_tick = 1'b1;
        do_req(12'hC01, 2'b00, 1'b1, "R4 time read with tick");
        dir_tick = 1'b0;
        do_req(12'hC01, 2'b11, 1'b1, "R4 time after tick");

        // R5: faulting retires are not counted
        dir_retire = 1'b1; dir_exc = 1'b1;
        repeat (6) @(negedge clk);
        dir_exc = 1'b0;
        repeat (3) @(negedge clk);
        dir_retire = 1'b0;
        do_req(12'hC02, 2'b00, 1'b1, "R5 instret counts clean retires");

        // R6: several generic counters together
        dir_ev = 4'b1011;
        repeat (5) @(negedge clk);
        dir_ev = 4'b0000;
        for (int k = 0; k < int'(NHPM); k++)
            do_req(12'hC03 + 12'(k), 2'b00, 1'b1, "R6 generic counter");

        // R8: write intent is refused, counter unaffected
        do_req(12'hC03, 2'b01, 1'b1, "R8 swap");
        do_req(12'hC84, 2'b10, 1'b0, "R8 set nonzero");
        do_req(12'hC01, 2'b11, 1'b0, "R8 clear nonzero");
        do_req(12'hC03, 2'b00, 1'b1, "R8 counter unchanged after writes");

        // R7: legal read forms
        do_req(12'hC04, 2'b10, 1'b1, "R7 set with zero operand");
        do_req(12'hC04, 2'b11, 1'b1, "R7 clear with zero operand");

        // R9: unimplemented slots
        do_req(12'hC07, 2'b00, 1'b1, "R9 first unimplemented slot");
        do_req(12'hC9F, 2'b00, 1'b1, "R9 last unimplemented slot");

        // R10: outside both windows
        do_req(12'hC20, 2'b00, 1'b1, "R10 above low window");
        do_req(12'hB00, 2'b01, 1'b1, "R10 unrelated address");

        // R2: upper halves of the fixed counters
        do_req(12'hC80, 2'b00, 1'b1, "R2 cycle upper half");
        do_req(12'hC82, 2'b00, 1'b1, "R2 instret upper half");

        // R1 / R2 / R7: random traffic with background events
        rand_en = 1'b1;
        for (int n = 0; n < 500; n++) begin
            logic [11:0] a;
            int sel = int'($urandom % 20);
            if (sel == 0) a = 12'hC20 + 12'($urandom % 64);
            else a = ($urandom % 2 == 1 ? 12'hC80 : 12'hC00) + 12'($urandom % 32);
            if ($urandom % 2 == 1) a = ($urandom % 2 == 1 ? 12'hC80 : 12'hC00)
                                       + 12'($urandom % NCTR);
            do_req(a, 2'($urandom), 1'($urandom % 4 != 0), "R1 R7 random access");
        end
        rand_en = 1'b0;
        @(negedge clk);
        check("R1 idle after traffic", rdata_a, ill_a, 32'h0, 1'b0);
        report();
    end

endmodule